// File: doc/BRIEF.md
# Per-Processor Interrupt Acceptance and Arbitration Unit

This block sits beside one processor and decides which interrupt that processor takes next. Interrupt messages arrive on a valid/ready stream. Each message carries a 3-bit delivery mode, an 8-bit vector, a trigger flag, an addressing-mode flag and a destination. If the destination matches the local identity, the message is accepted. Ordinary vectored messages are queued in a 256-bit request register, and the trigger flag is recorded for each vector. The four special kinds (system management, non-maskable, initialisation and external) each have one pending slot that holds the vector of the message that filled it.

The block drives `irq` while something is ready to be taken. A 256-bit in-service register and a task-priority input hold back vectored requests, and the processor interrupt-enable input gates the maskable kinds. `irq` acts as the valid of the output stream and `ack` as its ready. While `irq` is high, `out_kind` and `out_vector` describe the current winner, and an `ack` in that cycle takes the winner. The winner can change while `ack` is held low, because a message of higher rank may arrive in the meantime. `ack` has no effect while `irq` is low. On the input stream, `msg_ready` is high in every cycle out of reset, so a message is taken on any clock edge where `msg_valid` is high. An end-of-service pulse retires the highest in-service vector.

Top module: `intr_accept_arb`

## Requirements
- R1: After reset, `irq` is low, the request, in-service and trigger registers are empty, no special slot is pending, and `msg_ready` is high.
- R2: A message is accepted only if one of two conditions holds. With `msg_logical`=0, `msg_dest` must equal `local_id`. With `msg_logical`=1, bit `local_id` of `msg_dest` must be set. Any other message changes no state.
- R3: Mode codes are fixed=0, lowest-priority=1, SMI=2, NMI=4, INIT=5, external=7. Only codes 0 and 1 set a request bit. Codes 3 and 6 are reserved and change no state.
- R4: An accepted vectored message sets the trigger bit of its vector when `msg_level`=1 and clears it when `msg_level`=0. While a vectored winner is shown, `out_level` gives that bit.
- R5: Each special kind has one pending slot that stores the vector of its message. A message of that kind that arrives while the slot is full is dropped.
- R6: A pending SMI, NMI or INIT raises `irq` regardless of `intr_en`. A pending external or eligible vectored interrupt raises `irq` only while `intr_en`=1.
- R7: A vectored request is eligible when two conditions hold. Its highest vector must exceed the highest in-service vector, or the in-service register must be empty. Bits 7:4 of that vector must also be greater than `tpr[7:4]`.
- R8: The winner is taken in the order SMI, NMI, INIT, external, vectored. `out_kind` reports the winner's mode code, with 0 meaning vectored. An `ack` while `irq`=1 clears only the winner.
- R9: Taking a vectored winner sets its in-service bit and clears its request bit, after which the next highest request is shown.
- R10: An `eoi` pulse clears the highest set in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| local_id | input | 3 | Identity of this processor |
| msg_valid | input | 1 | Message present |
| msg_ready | output | 1 | Message can be taken (high out of reset) |
| msg_mode | input | 3 | Delivery mode code |
| msg_vector | input | 8 | Message vector |
| msg_level | input | 1 | 1 = level-triggered, 0 = edge |
| msg_logical | input | 1 | 1 = logical addressing, 0 = physical |
| msg_dest | input | 8 | Destination field |
| tpr | input | 8 | Task priority |
| intr_en | input | 1 | Processor interrupt enable |
| irq | output | 1 | Interrupt ready to be taken (output valid) |
| ack | input | 1 | Take the winner (output ready) |
| out_kind | output | 3 | Mode code of the winner |
| out_vector | output | 8 | Vector of the winner |
| out_level | output | 1 | Trigger bit of a vectored winner |
| eoi | input | 1 | Retire highest in-service vector |

## Verification
The hardest state to reach from the ports is the one where every special slot is full and a duplicate NMI with a different vector has been dropped. The same state also needs `intr_en` low, so that an external interrupt and a vectored request wait behind the special kinds. The bench builds this state one message at a time with `intr_en` held low. It then takes the winners one by one and checks the order and the stored vectors. Last, it raises `intr_en` to release the external interrupt ahead of the vectored one. A separate sequence puts a lower request behind a higher in-service vector and then retires that vector with `eoi`.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
  localparam int VEC_W   = 8;
  localparam int NVEC    = 1 << VEC_W;
  localparam int NSLOT   = 4;

  localparam logic [2:0] MODE_FIXED  = 3'd0;
  localparam logic [2:0] MODE_LOWEST = 3'd1;
  localparam logic [2:0] MODE_SMI    = 3'd2;
  localparam logic [2:0] MODE_NMI    = 3'd4;
  localparam logic [2:0] MODE_INIT   = 3'd5;
  localparam logic [2:0] MODE_EXT    = 3'd7;

  // slot index order is the service order
  localparam logic [2:0] SLOT_CODE [NSLOT] = '{MODE_SMI, MODE_NMI, MODE_INIT, MODE_EXT};
  localparam int UNMASK_SLOTS = 3;
endpackage

// File: rtl/hi_bit_find.sv
module hi_bit_find #(
  parameter int N = 256,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) begin
        idx_o = W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/special_slot.sv
module special_slot #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [VW-1:0] vec_i,
  output logic          pend_o,
  output logic [VW-1:0] vec_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      vec_o  <= '0;
    end else if (clr_i) begin
      pend_o <= 1'b0;
    end else if (set_i && !pend_o) begin
      pend_o <= 1'b1;
      vec_o  <= vec_i;
    end
  end
endmodule

// File: rtl/intr_accept_arb.sv
module intr_accept_arb
  import intr_arb_pkg::*;
#(
  parameter int DEST_W = 8,
  localparam int ID_W = $clog2(DEST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   local_id,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [2:0]        msg_mode,
  input  logic [VEC_W-1:0]  msg_vector,
  input  logic              msg_level,
  input  logic              msg_logical,
  input  logic [DEST_W-1:0] msg_dest,
  input  logic [VEC_W-1:0]  tpr,
  input  logic              intr_en,
  output logic              irq,
  input  logic              ack,
  output logic [2:0]        out_kind,
  output logic [VEC_W-1:0]  out_vector,
  output logic              out_level,
  input  logic              eoi
);
  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  logic [VEC_W-1:0] irr_idx, isr_idx;
  logic irr_any, isr_any;
  logic dest_hit, accept, is_vec, vec_ok, take, win_is_vec;
  logic [NSLOT-1:0] pend, slot_set, slot_clr;
  logic [VEC_W-1:0] slot_vec [NSLOT];
  logic [1:0] win_slot;

  assign msg_ready = rst_n;
  assign dest_hit  = msg_logical ? msg_dest[local_id] : (msg_dest == DEST_W'(local_id));
  assign accept    = msg_valid && msg_ready && dest_hit;
  assign is_vec    = (msg_mode == MODE_FIXED) || (msg_mode == MODE_LOWEST);

  hi_bit_find #(.N(NVEC)) u_irr_find (.bits_i(irr_q), .idx_o(irr_idx), .any_o(irr_any));
  hi_bit_find #(.N(NVEC)) u_isr_find (.bits_i(isr_q), .idx_o(isr_idx), .any_o(isr_any));

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      assign slot_set[g] = accept && (msg_mode == SLOT_CODE[g]);
      assign slot_clr[g] = take && !win_is_vec && (win_slot == 2'(g));
      special_slot #(.VW(VEC_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .set_i(slot_set[g]), .clr_i(slot_clr[g]),
        .vec_i(msg_vector), .pend_o(pend[g]), .vec_o(slot_vec[g]));
    end
  endgenerate

  assign vec_ok = irr_any && (!isr_any || (irr_idx > isr_idx)) &&
                  (irr_idx[VEC_W-1:VEC_W-4] > tpr[VEC_W-1:VEC_W-4]);
  assign irq = (|pend[UNMASK_SLOTS-1:0]) || (intr_en && (pend[NSLOT-1] || vec_ok));
  assign take = irq && ack;

  always_comb begin
    win_is_vec = 1'b1;
    win_slot   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win_is_vec = 1'b0;
        win_slot   = 2'(i);
      end
    end
  end

  assign out_kind   = win_is_vec ? MODE_FIXED : SLOT_CODE[win_slot];
  assign out_vector = win_is_vec ? irr_idx : slot_vec[win_slot];
  assign out_level  = win_is_vec && tmr_q[irr_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else begin
      if (take && win_is_vec) begin
        irr_q[irr_idx] <= 1'b0;
        isr_q[irr_idx] <= 1'b1;
      end
      if (eoi && isr_any) isr_q[isr_idx] <= 1'b0;
      if (accept && is_vec) begin
        irr_q[msg_vector] <= 1'b1;
        tmr_q[msg_vector] <= msg_level;
      end
    end
  end
endmodule

// File: rtl/intr_accept_chk.sv
module intr_accept_chk
  import intr_arb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [2:0]       msg_mode,
  input logic             intr_en,
  input logic             irq,
  input logic             ack,
  input logic             eoi,
  input logic [2:0]       out_kind,
  input logic [VEC_W-1:0] out_vector,
  input logic [VEC_W-1:0] tpr,
  input logic [NVEC-1:0]  irr_q,
  input logic [NVEC-1:0]  isr_q,
  input logic [NSLOT-1:0] pend
);
  // R3
  reserved_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_mode == 3'd3 || msg_mode == 3'd6) && !ack && !eoi)
    |=> ($stable(irr_q) && $stable(pend)));
  // R6
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !intr_en) |-> (out_kind != MODE_FIXED && out_kind != MODE_EXT));
  // R8
  nmi_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && out_kind == MODE_NMI) |-> !pend[0]);
  // R7
  tpr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && out_kind == MODE_FIXED) |-> (out_vector[7:4] > tpr[7:4]));
  // R9
  in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack && out_kind == MODE_FIXED && !eoi) |=> isr_q[$past(out_vector)]);
endmodule

bind intr_accept_arb intr_accept_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_mode(msg_mode),
  .intr_en(intr_en), .irq(irq), .ack(ack), .eoi(eoi), .out_kind(out_kind),
  .out_vector(out_vector), .tpr(tpr), .irr_q(irr_q), .isr_q(isr_q), .pend(pend));

// File: tb/intr_accept_arb_bench.sv
module intr_accept_arb_bench;
  logic clk = 0, rst_n = 0;
  logic [2:0] local_id = 3'd3;
  logic msg_valid = 0, msg_ready, msg_level = 0, msg_logical = 0;
  logic [2:0] msg_mode = 0;
  logic [7:0] msg_vector = 0, msg_dest = 0, tpr = 0;
  logic intr_en = 1, irq, ack = 0, out_level, eoi = 0;
  logic [2:0] out_kind;
  logic [7:0] out_vector;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  intr_accept_arb u_intr_accept_arb (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] m, input logic [7:0] v, input logic lvl,
                      input logic lg, input logic [7:0] d);
    msg_mode = m; msg_vector = v; msg_level = lvl; msg_logical = lg; msg_dest = d;
    msg_valid = 1;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic take(input string req, input int kind, input int vec);
    chk({req, " irq"}, irq, 1);
    chk({req, " kind"}, out_kind, kind);
    chk({req, " vector"}, out_vector, vec);
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic pulse_eoi();
    eoi = 1;
    @(negedge clk);
    eoi = 0;
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 ready", msg_ready, 1);
  endtask

  task automatic t_dest_trig();
    send(3'd0, 8'h45, 0, 0, 8'd3);
    chk("R2 physical hit", out_vector, 8'h45);
    chk("R4 edge", out_level, 0);
    send(3'd0, 8'h80, 0, 0, 8'd4);
    chk("R2 physical miss", out_vector, 8'h45);
    send(3'd1, 8'h90, 0, 1, 8'b1111_0111);
    chk("R2 logical miss", out_vector, 8'h45);
    send(3'd1, 8'h60, 1, 1, 8'b0000_1000);
    chk("R2 logical hit", out_vector, 8'h60);
    chk("R4 level", out_level, 1);
    send(3'd0, 8'h60, 0, 0, 8'd3);
    chk("R4 re-edge", out_level, 0);
  endtask

  task automatic t_tpr_isr();
    tpr = 8'h60; #1;
    chk("R7 tpr equal blocks", irq, 0);
    tpr = 8'h5F; #1;
    chk("R7 tpr lower passes", irq, 1);
    tpr = 0;
    take("R9 take 60", 0, 8'h60);
    chk("R7 below in-service", irq, 0);
    pulse_eoi();
    chk("R10 eoi releases", irq, 1);
    take("R9 take 45", 0, 8'h45);
    chk("R9 request cleared", irq, 0);
    pulse_eoi();
    chk("R10 no request left", irq, 0);
  endtask

  task automatic t_reserved();
    send(3'd3, 8'h90, 0, 0, 8'd3);
    chk("R3 code 3", irq, 0);
    send(3'd6, 8'h91, 0, 0, 8'd3);
    chk("R3 code 6", irq, 0);
    ack = 1; @(negedge clk); ack = 0;
    chk("R8 ack ignored when idle", irq, 0);
  endtask

  task automatic t_special();
    intr_en = 0;
    send(3'd7, 8'h21, 0, 0, 8'd3);
    send(3'd0, 8'hA0, 0, 0, 8'd3);
    chk("R6 masked ext/vec", irq, 0);
    send(3'd4, 8'h02, 0, 0, 8'd3);
    chk("R6 nmi unmasked", out_kind, 4);
    send(3'd2, 8'h11, 0, 0, 8'd3);
    send(3'd5, 8'h77, 0, 0, 8'd3);
    send(3'd4, 8'h99, 0, 0, 8'd3);
    take("R8 smi first", 2, 8'h11);
    take("R5 nmi kept first vector", 4, 8'h02);
    take("R8 init", 5, 8'h77);
    chk("R6 ext held by enable", irq, 0);
    intr_en = 1; #1;
    take("R8 ext before vectored", 7, 8'h21);
    take("R8 vectored last", 0, 8'hA0);
    pulse_eoi();
    chk("R5 duplicate dropped", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dest_trig();
    t_tpr_isr();
    t_reserved();
    t_special();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule